// File: doc/BRIEF.md
# Reloadable Up-Counting Interval Timer

This block is a 16-bit timer that counts upward from a programmable start value to a fixed terminal count of 0xFFFF. On the count step after the terminal count it restarts from the start value, so a start value X gives a period of 65536 − X count steps. It runs on the system clock, and a count step happens on a qualified source event. That event is either an internal tick made by dividing the system clock, or a rising edge of an external clock pin after it has been synchronised.

Software programs the timer through a small byte-wide register window. The window gives access to the 16-bit start value, which is built from a staged low byte and committed when the high byte is written. It also gives a snapshot register that captures the live count on command, a control register and a status register. The control register holds source select, a two-bit operating mode (load, hold, free-run and gated) and interrupt enable. Outputs are a terminal-count pulse, an interrupt pulse and a sticky overflow flag.

Top module: `tmr_top`

## Requirements
- R1: After reset, the count, start value, snapshot and staged byte are 0, the mode is hold (code 01), the source is the internal tick, interrupts are disabled, and ovf_o, irq_o and flag_o are low. Register offsets are: 0 for snapshot/start low byte, 1 for snapshot/start high byte, 2 for control and 3 for status.
- R2: A write to offset 0 only stages a low byte. A write to offset 1 commits {written byte, staged byte} as the start value in one step. Reads of offsets 0 and 1 return the snapshot bytes and never the live count. Reads have one cycle of latency.
- R3: Writing control with bit 5 set copies the whole 16-bit count into the snapshot in a single cycle. The other control fields are written from the same byte.
- R4: Control bit 0 selects the source. With 0, a count step happens once every CLK_DIV system cycles. With 1, a count step happens once per rising edge of ext_clk_i after a two-flop synchroniser.
- R5: Mode 00 (control bits 2:1) loads the start value into the count on each count step and never raises ovf_o.
- R6: Mode 01 holds the count unchanged.
- R7: Mode 10 adds one per count step. From 0xFFFF the next step loads the start value, so X = 0xFFFE divides by 2.
- R8: Mode 11 counts as mode 10 while the synchronised ext_gate_i is high and holds while it is low.
- R9: A start value written while counting does not move the count. It is used at the next restart after 0xFFFF.
- R10: ovf_o is high for one system cycle each time a counting step leaves the count at 0xFFFF. With a start value of 0xFFFF the count stays at 0xFFFF and ovf_o pulses on every step.
- R11: irq_o pulses one cycle after each ovf_o pulse when control bit 3 is 1, and never pulses when that bit is 0.
- R12: Status bit 0 (flag_o) is set one cycle after every ovf_o pulse, whatever the interrupt enable. Reading it does not clear it. Writing control with bit 4 set clears it, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the offset on bus_addr |
| ext_clk_i | input | 1 | Asynchronous external count source |
| ext_gate_i | input | 1 | Asynchronous gate for mode 11 |
| ovf_o | output | 1 | One-cycle pulse when the count reaches 0xFFFF |
| irq_o | output | 1 | Interrupt pulse |
| flag_o | output | 1 | Sticky overflow status |

## Verification
The assertions assume that a count step is a one-cycle event. They also assume that mode and start value change only through register writes, so hold and load behaviour can be checked against the previous cycle's mode. The bench keeps each external clock level for four system cycles and changes the gate only while no edge is in flight, so every edge gives exactly one step. The bench writes nothing else while it expects a terminal count, so pulses are never hidden by clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_HOLD = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_GATE = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] OFS_LO   = 2'd0;
  localparam logic [1:0] OFS_HI   = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int CTL_SRC   = 0;
  localparam int CTL_MODE  = 1;
  localparam int CTL_IEN   = 3;
  localparam int CTL_CLR   = 4;
  localparam int CTL_SNAP  = 5;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (phase == LAST);
      phase  <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      prev   <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_i};
      prev   <= chain[STAGES-1];
      rise_o <= chain[STAGES-1] & ~prev;
    end
  end

  assign level_o = chain[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  tmr_mode_e    mode_i,
  input  logic         gate_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] TOP = '1;

  logic         adv, load;
  logic [W-1:0] nxt;

  always_comb begin
    adv  = step_i && ((mode_i == MODE_RUN) || ((mode_i == MODE_GATE) && gate_i));
    load = step_i && (mode_i == MODE_LOAD);
    nxt  = (cnt_o == TOP) ? reload_i : cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (adv)       cnt_o <= nxt;
      else if (load) cnt_o <= reload_i;
      ovf_o <= adv && (nxt == TOP);
    end
  end

  // R10
  ovf_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_o == TOP));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode_i == MODE_HOLD) |-> (cnt_o == $past(cnt_o)));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(step_i && mode_i == MODE_LOAD) |-> (cnt_o == $past(reload_i) && !ovf_o));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CLK_DIV  = 200,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk_i,
  input  logic       ext_gate_i,
  output logic       ovf_o,
  output logic       irq_o,
  output logic       flag_o
);
  localparam int W = 16;

  logic         int_tick, ext_rise, ext_lvl, gate_lvl, gate_rise;
  logic         src_ext, irq_en, step;
  tmr_mode_e    mode;
  logic [7:0]   lo_stage;
  logic [W-1:0] reload, snap, cnt;
  logic         ovf_core;
  logic         wr_ctrl;

  tmr_tick_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick_o(int_tick));

  tmr_edge_sync #(.STAGES(SYNC_LEN)) u_clk_sync (
    .clk(clk), .rst(rst), .async_i(ext_clk_i), .level_o(ext_lvl), .rise_o(ext_rise));

  tmr_edge_sync #(.STAGES(SYNC_LEN)) u_gate_sync (
    .clk(clk), .rst(rst), .async_i(ext_gate_i), .level_o(gate_lvl), .rise_o(gate_rise));

  assign step    = src_ext ? ext_rise : int_tick;
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .step_i(step), .mode_i(mode), .gate_i(gate_lvl),
    .reload_i(reload), .cnt_o(cnt), .ovf_o(ovf_core));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= '0;
      reload   <= '0;
      snap     <= '0;
      src_ext  <= 1'b0;
      irq_en   <= 1'b0;
      mode     <= MODE_HOLD;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_LO: lo_stage <= bus_wdata;
        OFS_HI: reload   <= {bus_wdata, lo_stage};
        OFS_CTRL: begin
          src_ext <= bus_wdata[CTL_SRC];
          mode    <= tmr_mode_e'(bus_wdata[CTL_MODE +: 2]);
          irq_en  <= bus_wdata[CTL_IEN];
          if (bus_wdata[CTL_SNAP]) snap <= cnt;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      irq_o <= ovf_core && irq_en;
      if (ovf_core)                               flag_o <= 1'b1;
      else if (wr_ctrl && bus_wdata[CTL_CLR])     flag_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFS_LO:   bus_rdata <= snap[7:0];
        OFS_HI:   bus_rdata <= snap[15:8];
        OFS_CTRL: bus_rdata <= {4'b0, irq_en, mode, src_ext};
        default:  bus_rdata <= {7'b0, flag_o};
      endcase
    end
  end

  assign ovf_o = ovf_core;

  logic unused_ok;
  assign unused_ok = ext_lvl ^ gate_rise;

  // R11
  irq_follows_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(ovf_core) && $past(irq_en)));

  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_core |=> flag_o);

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_o) |-> ($past(wr_ctrl && bus_wdata[CTL_CLR]) && !$past(ovf_core)));
endmodule

// File: tb/tmr_top_test.sv
module tmr_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_i = 1'b0;
  logic       ext_gate_i = 1'b0;
  logic       ovf_o, irq_o, flag_o;

  int n_chk = 0;
  int n_bad = 0;
  int ovf_seen = 0;
  int irq_seen = 0;
  logic [7:0] ctl_sh = 8'h02;

  always #2.5 clk = ~clk;

  tmr_top #(.CLK_DIV(4), .SYNC_LEN(2)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_i(ext_clk_i),
    .ext_gate_i(ext_gate_i), .ovf_o(ovf_o), .irq_o(irq_o), .flag_o(flag_o));

  always @(negedge clk) begin
    if (!rst && ovf_o) ovf_seen++;
    if (!rst && irq_o) irq_seen++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_ctl(logic [7:0] v);
    ctl_sh = v & 8'h0F;
    wr(2'd2, ctl_sh);
  endtask

  task automatic snap_count(output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(2'd2, ctl_sh | 8'h20);
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_reload(logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk_i = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic preload(logic [15:0] v);
    set_reload(v);
    set_ctl(8'h01);
    pulse(1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] c;
    rd(2'd2, d); check("R1 ctrl", d, 8'h02);
    rd(2'd3, d); check("R1 status", d, 8'h00);
    check("R1 outputs", {ovf_o, irq_o, flag_o}, 3'b000);
    snap_count(c); check("R1 count", c, 16'h0000);
  endtask

  task automatic t_load_hold_run;
    logic [15:0] c;
    set_ctl(8'h03);
    pulse(2);
    snap_count(c); check("R6 hold ext", c, 16'h0000);
    set_reload(16'h1234);
    set_ctl(8'h01);
    ovf_seen = 0;
    pulse(2);
    snap_count(c); check("R5 load", c, 16'h1234);
    check("R5 no ovf", ovf_seen, 0);
    set_ctl(8'h05);
    pulse(3);
    snap_count(c); check("R7 run", c, 16'h1237);
    set_ctl(8'h03);
    pulse(2);
    snap_count(c); check("R6 hold", c, 16'h1237);
  endtask

  task automatic t_staging;
    logic [15:0] c;
    logic [7:0] d;
    set_reload(16'h0100);
    wr(2'd0, 8'h77);
    set_ctl(8'h01);
    pulse(1);
    snap_count(c); check("R2 staged only", c, 16'h0100);
    wr(2'd1, 8'h12);
    pulse(1);
    snap_count(c); check("R2 commit", c, 16'h1277);
    set_ctl(8'h05);
    pulse(1);
    rd(2'd0, d); check("R2 read is snapshot", d, 8'h77);
  endtask

  task automatic t_gate;
    logic [15:0] c;
    preload(16'h0040);
    ext_gate_i = 1'b0;
    set_ctl(8'h07);
    repeat (4) @(negedge clk);
    pulse(3);
    snap_count(c); check("R8 gate low", c, 16'h0040);
    ext_gate_i = 1'b1;
    repeat (4) @(negedge clk);
    pulse(3);
    snap_count(c); check("R8 gate high", c, 16'h0043);
    ext_gate_i = 1'b0;
  endtask

  task automatic t_wrap_irq;
    logic [15:0] c;
    logic [7:0] d;
    preload(16'hFFFD);
    set_ctl(8'h0D);
    ovf_seen = 0; irq_seen = 0;
    pulse(3);
    snap_count(c); check("R7 wrap", c, 16'hFFFD);
    check("R10 one ovf", ovf_seen, 1);
    check("R11 irq on", irq_seen, 1);
    rd(2'd3, d); check("R12 set", d, 8'h01);
    rd(2'd3, d); check("R12 read keeps", d, 8'h01);
    wr(2'd2, ctl_sh | 8'h10);
    rd(2'd3, d); check("R12 clear", d, 8'h00);
    check("R12 pin", flag_o, 1'b0);
  endtask

  task automatic t_irq_off;
    logic [7:0] d;
    preload(16'hFFFE);
    set_ctl(8'h05);
    ovf_seen = 0; irq_seen = 0;
    pulse(10);
    check("R7 divide by 2", ovf_seen, 5);
    check("R11 irq off", irq_seen, 0);
    rd(2'd3, d); check("R12 set w/o irq", d, 8'h01);
    wr(2'd2, ctl_sh | 8'h10);
  endtask

  task automatic t_midcycle;
    logic [15:0] c;
    preload(16'hFFFD);
    set_ctl(8'h05);
    pulse(1);
    set_reload(16'h0100);
    snap_count(c); check("R9 no jump", c, 16'hFFFE);
    pulse(2);
    snap_count(c); check("R9 new at wrap", c, 16'h0100);
    snap_count(c); check("R3 repeat snap", c, 16'h0100);
  endtask

  task automatic t_stick;
    logic [15:0] c;
    preload(16'hFFFF);
    set_ctl(8'h05);
    ovf_seen = 0;
    pulse(3);
    snap_count(c); check("R10 stuck", c, 16'hFFFF);
    check("R10 ovf each step", ovf_seen, 3);
    wr(2'd2, ctl_sh | 8'h10);
  endtask

  task automatic t_internal;
    logic [15:0] a, b;
    set_reload(16'h0000);
    set_ctl(8'h00);
    repeat (8) @(negedge clk);
    set_ctl(8'h04);
    repeat (3) @(negedge clk);
    snap_count(a);
    repeat (34) @(negedge clk);
    snap_count(b);
    check("R4 internal rate", b - a, 16'd10);
    check("R3 snapshot differs", (b != a), 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_hold_run();
        t_staging();
        t_gate();
        t_wrap_irq();
        t_irq_off();
        t_midcycle();
        t_stick();
        t_internal();
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule